// File: doc/BRIEF.md
# Sa-Bit Multiframe Buffers

This block is a bank of national-bit buffers for an E1 CRC-4 multiframe. Each byte holds one Sa position (Sa4 to Sa8), collected over the eight odd-numbered frames of a 16-frame multiframe. There are five transmit bytes and five receive bytes.

Software writes the transmit bytes over a small register bus. At each multiframe start, the block takes a working copy of those bytes. It then presents, frame by frame, the five Sa bits that the framer inserts into the outgoing stream.

On the receive side, the block picks the five Sa bits out of every odd frame, as the framer extracts them, and collects them in a shadow. At the last frame it publishes them to readable snapshot registers and raises a one-cycle flag. It does this only while multiframe alignment is reported valid, and only when the whole multiframe was seen.

Top module: `sa_mframe_buf`

## Requirements
- R1: After reset, the five transmit bytes read 8'hFF, the five receive bytes read 8'h00, `rx_new` is 0 and `bus_rdata` is 0.
- R2: The register map is as follows. Addresses 0 to 4 are the transmit bytes for Sa4..Sa8 and can be read and written. Addresses 8 to 12 are the receive bytes for Sa4..Sa8. Every other address reads 0 and ignores writes. Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.
- R3: In odd frame n (1..15), the bit used is byte bit 7-(n-1)/2, so F1 maps to bit 7 and F15 to bit 0. Port bit k of `tx_sa` and `rx_sa` carries Sa(4+k), which belongs to byte k.
- R4: While `tx_frm_num` is even, `tx_sa` is 5'b11111.
- R5: The transmit bits come from a working copy. That copy is loaded from the transmit bytes only on a `tx_frm_stb` with `tx_frm_num` = 0, so a write during a multiframe takes effect at the next frame 0.
- R6: A `rx_frm_stb` with `rx_mf_valid` = 1 and an odd `rx_frm_num` stores `rx_sa` into the shadow. The strobe of frame 15 copies the shadow, including that frame's bits, to the receive bytes, and `rx_new` is 1 for exactly the following cycle. Strobes in even frames store nothing.
- R7: While `rx_mf_valid` is 0, received bits are neither stored nor published, the receive bytes keep their last values, and `rx_new` stays 0.
- R8: A frame-15 strobe publishes only if frame 1 was stored since `rx_mf_valid` was last 0 and since the previous publish. Otherwise the receive bytes hold and `rx_new` stays 0.
- R9: Writes to addresses 8 to 12 leave the receive bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tx_frm_stb | input | 1 | Start of a transmit frame |
| tx_frm_num | input | 4 | Transmit frame number within the multiframe |
| tx_sa | output | 5 | Sa8..Sa4 bits for the current transmit frame |
| rx_frm_stb | input | 1 | Receive Sa bits are present |
| rx_frm_num | input | 4 | Receive frame number within the multiframe |
| rx_mf_valid | input | 1 | Receive multiframe alignment held |
| rx_sa | input | 5 | Sa8..Sa4 bits extracted from the receive frame |
| rx_new | output | 1 | One-cycle pulse when new receive bytes are published |

## Verification
The assertions assume that frame strobes come from a counter that is at least a few cycles apart, so two frame-15 strobes never fall on adjacent cycles. They also assume that the transmit frame number stays steady between strobes. The stimulus drives one strobe per frame and holds the frame number for several idle cycles around each strobe. It walks frame numbers in multiframe order, or starts part-way through to model a realignment, and inserts register writes only between frames. Sa bit values and register data are drawn at random from a fixed seed.

// File: rtl/sa_buf_pkg.sv
package sa_buf_pkg;
  localparam int SA_COUNT   = 5;
  localparam int FRAME_BITS = 4;
  localparam int BYTE_BITS  = 1 << (FRAME_BITS - 1);
  localparam int ADR_BITS   = 4;
endpackage

// File: rtl/sa_tx_bank.sv
module sa_tx_bank #(
  parameter int N_SA  = sa_buf_pkg::SA_COUNT,
  parameter int FRM_W = sa_buf_pkg::FRAME_BITS
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [N_SA-1:0]                         wr_sel,
  input  logic [(1<<(FRM_W-1))-1:0]               wr_data,
  input  logic                                    frm_stb,
  input  logic [FRM_W-1:0]                        frm_num,
  output logic [N_SA-1:0][(1<<(FRM_W-1))-1:0]     cfg,
  output logic [N_SA-1:0][(1<<(FRM_W-1))-1:0]     work,
  output logic [N_SA-1:0]                         sa_out
);
  localparam int BYTE_W = 1 << (FRM_W - 1);
  localparam int IDX_W  = FRM_W - 1;

  logic [N_SA-1:0][BYTE_W-1:0] cfg_d, work_d;
  logic                        load_en;
  logic [IDX_W-1:0]            bpos;

  assign load_en = frm_stb && (frm_num == '0);
  assign bpos    = ~frm_num[FRM_W-1:1];

  always_comb begin
    cfg_d = cfg;
    for (int k = 0; k < N_SA; k++) begin
      if (wr_sel[k]) cfg_d[k] = wr_data;
    end
  end

  always_comb begin
    work_d = work;
    if (load_en) work_d = cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '1;
      work <= '1;
    end else begin
      cfg  <= cfg_d;
      work <= work_d;
    end
  end

  generate
    for (genvar g = 0; g < N_SA; g++) begin : g_sa
      assign sa_out[g] = frm_num[0] ? work[g][bpos] : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/sa_rx_bank.sv
module sa_rx_bank #(
  parameter int N_SA  = sa_buf_pkg::SA_COUNT,
  parameter int FRM_W = sa_buf_pkg::FRAME_BITS
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    frm_stb,
  input  logic [FRM_W-1:0]                        frm_num,
  input  logic                                    mf_valid,
  input  logic [N_SA-1:0]                         sa_in,
  output logic [N_SA-1:0][(1<<(FRM_W-1))-1:0]     snap,
  output logic                                    new_mf
);
  localparam int BYTE_W = 1 << (FRM_W - 1);
  localparam int IDX_W  = FRM_W - 1;
  localparam logic [FRM_W-1:0] FIRST_NUM = FRM_W'(1);
  localparam logic [FRM_W-1:0] LAST_NUM  = {FRM_W{1'b1}};

  logic [N_SA-1:0][BYTE_W-1:0] shadow_q, shadow_d, snap_d;
  logic                        head_q, head_d, new_d;
  logic [IDX_W-1:0]            bpos;

  assign bpos = ~frm_num[FRM_W-1:1];

  always_comb begin
    shadow_d = shadow_q;
    snap_d   = snap;
    head_d   = head_q;
    new_d    = 1'b0;
    if (!mf_valid) begin
      head_d = 1'b0;
    end else if (frm_stb && frm_num[0]) begin
      for (int k = 0; k < N_SA; k++) begin
        shadow_d[k][bpos] = sa_in[k];
      end
      if (frm_num == FIRST_NUM) head_d = 1'b1;
      if (frm_num == LAST_NUM && head_q) begin
        snap_d = shadow_d;
        new_d  = 1'b1;
        head_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      snap     <= '0;
      head_q   <= 1'b0;
      new_mf   <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      snap     <= snap_d;
      head_q   <= head_d;
      new_mf   <= new_d;
    end
  end
endmodule

// File: rtl/sa_mframe_buf.sv
module sa_mframe_buf #(
  parameter int N_SA   = sa_buf_pkg::SA_COUNT,
  parameter int FRM_W  = sa_buf_pkg::FRAME_BITS,
  parameter int ADDR_W = sa_buf_pkg::ADR_BITS
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_en,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [(1<<(FRM_W-1))-1:0]     bus_wdata,
  output logic [(1<<(FRM_W-1))-1:0]     bus_rdata,
  input  logic                          tx_frm_stb,
  input  logic [FRM_W-1:0]              tx_frm_num,
  output logic [N_SA-1:0]               tx_sa,
  input  logic                          rx_frm_stb,
  input  logic [FRM_W-1:0]              rx_frm_num,
  input  logic                          rx_mf_valid,
  input  logic [N_SA-1:0]               rx_sa,
  output logic                          rx_new
);
  localparam int BYTE_W = 1 << (FRM_W - 1);
  localparam int OFS_W  = ADDR_W - 1;

  logic [N_SA-1:0][BYTE_W-1:0] tx_cfg, tx_work, rx_snap;
  logic [N_SA-1:0]             tx_wr;
  logic [BYTE_W-1:0]           rd_d;
  logic                        rd_en;
  logic                        is_rx;
  logic [OFS_W-1:0]            ofs;

  assign is_rx = bus_addr[ADDR_W-1];
  assign ofs   = bus_addr[OFS_W-1:0];
  assign rd_en = bus_en && !bus_we;

  always_comb begin
    for (int k = 0; k < N_SA; k++) begin
      tx_wr[k] = bus_en && bus_we && !is_rx && (ofs == OFS_W'(k));
    end
  end

  always_comb begin
    rd_d = '0;
    for (int k = 0; k < N_SA; k++) begin
      if (ofs == OFS_W'(k)) rd_d = is_rx ? rx_snap[k] : tx_cfg[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_d;
  end

  sa_tx_bank #(.N_SA(N_SA), .FRM_W(FRM_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .wr_sel(tx_wr), .wr_data(bus_wdata),
    .frm_stb(tx_frm_stb), .frm_num(tx_frm_num),
    .cfg(tx_cfg), .work(tx_work), .sa_out(tx_sa)
  );

  sa_rx_bank #(.N_SA(N_SA), .FRM_W(FRM_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frm_stb(rx_frm_stb), .frm_num(rx_frm_num),
    .mf_valid(rx_mf_valid), .sa_in(rx_sa), .snap(rx_snap), .new_mf(rx_new)
  );
endmodule

// File: rtl/sa_mframe_buf_chk.sv
module sa_mframe_buf_chk #(
  parameter int N_SA   = 5,
  parameter int FRM_W  = 4,
  parameter int ADDR_W = 4
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                bus_en,
  input logic                                bus_we,
  input logic [ADDR_W-1:0]                   bus_addr,
  input logic [(1<<(FRM_W-1))-1:0]           bus_rdata,
  input logic                                tx_frm_stb,
  input logic [FRM_W-1:0]                    tx_frm_num,
  input logic [N_SA-1:0]                     tx_sa,
  input logic [N_SA-1:0][(1<<(FRM_W-1))-1:0] tx_work,
  input logic                                rx_frm_stb,
  input logic [FRM_W-1:0]                    rx_frm_num,
  input logic                                rx_mf_valid,
  input logic                                rx_new,
  input logic [N_SA-1:0][(1<<(FRM_W-1))-1:0] rx_snap
);
  logic unmapped;
  assign unmapped = (bus_addr[ADDR_W-2:0] >= (ADDR_W-1)'(N_SA));

  AST_NEW_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |-> $past(rx_frm_stb && rx_mf_valid && (rx_frm_num == {FRM_W{1'b1}}))); // R6
  AST_NEW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_new |=> !rx_new); // R6
  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_new |-> $stable(rx_snap)); // R7
  AST_TX_EVEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_frm_num[0] |-> (tx_sa == {N_SA{1'b1}})); // R4
  AST_TX_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_frm_stb && (tx_frm_num == '0)) |-> $stable(tx_work)); // R5
  AST_RDATA_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_en && !bus_we && unmapped) |-> (bus_rdata == '0)); // R2
endmodule

bind sa_mframe_buf sa_mframe_buf_chk #(.N_SA(N_SA), .FRM_W(FRM_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tx_frm_stb(tx_frm_stb), .tx_frm_num(tx_frm_num), .tx_sa(tx_sa),
  .tx_work(tx_work), .rx_frm_stb(rx_frm_stb), .rx_frm_num(rx_frm_num),
  .rx_mf_valid(rx_mf_valid), .rx_new(rx_new), .rx_snap(rx_snap)
);

// File: tb/sa_mframe_buf_bench.sv
module sa_mframe_buf_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tx_frm_stb = 1'b0;
  logic [3:0] tx_frm_num = 4'd1;
  logic [4:0] tx_sa;
  logic       rx_frm_stb = 1'b0;
  logic [3:0] rx_frm_num = '0;
  logic       rx_mf_valid = 1'b0;
  logic [4:0] rx_sa = '0;
  logic       rx_new;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;
  logic [7:0] m_cfg[5], m_work[5], m_shadow[5], m_snap[5], cur[5];
  bit  m_head = 0;

  always #2.5 clk = ~clk;

  sa_mframe_buf u_sa_mframe_buf (.*);

  function automatic logic [4:0] exp_tx(input logic [3:0] n);
    logic [4:0] v;
    for (int k = 0; k < 5; k++) v[k] = n[0] ? m_work[k][3'd7 - n[3:1]] : 1'b1;
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    if (a < 5) m_cfg[a] = d;
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic tx_frame(input logic [3:0] n);
    @(negedge clk); tx_frm_num = n; tx_frm_stb = 1;
    @(negedge clk); tx_frm_stb = 0;
    if (n == 0) for (int k = 0; k < 5; k++) m_work[k] = m_cfg[k];
    if (n[0]) check("R3 tx odd-frame bits", tx_sa, exp_tx(n));
    else      check("R4 tx even-frame ones", tx_sa, 5'h1f);
    @(negedge clk);
  endtask

  task automatic rx_frame(input logic [3:0] n, input logic [4:0] b, input bit v);
    bit pub = 0;
    @(negedge clk); rx_frm_num = n; rx_sa = b; rx_mf_valid = v; rx_frm_stb = 1;
    if (!v) m_head = 0;
    else if (n[0]) begin
      for (int k = 0; k < 5; k++) m_shadow[k][3'd7 - n[3:1]] = b[k];
      if (n == 1) m_head = 1;
      if (n == 15 && m_head) begin
        for (int k = 0; k < 5; k++) m_snap[k] = m_shadow[k];
        pub = 1; m_head = 0;
      end
    end
    @(negedge clk); rx_frm_stb = 0;
    check("R6/R7/R8 rx_new pulse", rx_new, pub);
    @(negedge clk);
    check("R6 rx_new one cycle", rx_new, 0);
  endtask

  task automatic rx_mframe(input int first, input bit v);
    for (int k = 0; k < 5; k++) cur[k] = 8'($urandom);
    for (int n = first; n < 16; n++) begin
      logic [4:0] b;
      for (int k = 0; k < 5; k++) b[k] = n[0] ? cur[k][7 - n/2] : 1'($urandom);
      rx_frame(4'(n), b, v);
    end
  endtask

  task automatic check_rx_regs(input string tag);
    logic [7:0] d;
    for (int k = 0; k < 5; k++) begin
      bus_read(4'(8 + k), d);
      check(tag, d, m_snap[k]);
    end
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5A4E_0017));
    for (int k = 0; k < 5; k++) begin
      m_cfg[k] = 8'hFF; m_work[k] = 8'hFF; m_shadow[k] = 8'h00; m_snap[k] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 rx_new reset", rx_new, 0);
    check("R1 rdata reset", bus_rdata, 0);
    for (int k = 0; k < 5; k++) begin
      bus_read(4'(k), d);     check("R1 tx byte reset", d, 8'hFF);
      bus_read(4'(8 + k), d); check("R1 rx byte reset", d, 8'h00);
    end
    // R4, R3 with reset working copy
    for (int n = 0; n < 16; n++) tx_frame(4'(n));
    // directed corner: single-bit patterns to pin F1->bit7, F15->bit0 (R3)
    bus_write(0, 8'h80); bus_write(4, 8'h01);
    for (int n = 0; n < 16; n++) tx_frame(4'(n));
    // random transmit multiframes with mid-frame writes (R5)
    for (int it = 0; it < 6; it++) begin
      for (int k = 0; k < 5; k++) bus_write(4'(k), 8'($urandom));
      for (int n = 0; n < 16; n++) begin
        tx_frame(4'(n));
        if (n == 6) begin
          bus_write(4'($urandom_range(0, 4)), 8'($urandom));
          tx_frame(4'(n)); // R5 working copy unchanged mid-multiframe
        end
      end
      for (int k = 0; k < 5; k++) begin
        bus_read(4'(k), d); check("R2 tx readback", d, m_cfg[k]);
      end
    end
    // unmapped addresses (R2)
    bus_write(4'd6, 8'hA5); bus_read(4'd6, d);  check("R2 unmapped read", d, 0);
    bus_write(4'd14, 8'h5A); bus_read(4'd14, d); check("R2 unmapped rx half", d, 0);
    // receive multiframes (R6, R3)
    for (int it = 0; it < 5; it++) begin
      rx_mframe(0, 1);
      check_rx_regs("R6 rx snapshot");
    end
    // R9 writes to receive bytes ignored
    bus_write(4'd8, ~m_snap[0]); bus_write(4'd12, ~m_snap[4]);
    check_rx_regs("R9 rx write ignored");
    // R7 alignment lost: nothing published
    rx_mframe(0, 0);
    check_rx_regs("R7 snapshot held");
    // R8 partial multiframe after realign
    rx_mframe(7, 1);
    check_rx_regs("R8 partial not published");
    rx_mframe(0, 1);
    check_rx_regs("R8 full after realign");
    // R8 valid drops mid-multiframe
    for (int n = 0; n < 8; n++) rx_frame(4'(n), 5'($urandom), 1);
    rx_frame(4'd8, 5'h0, 0);
    for (int n = 9; n < 16; n++) rx_frame(4'(n), 5'($urandom), 1);
    check_rx_regs("R8 dropped-valid not published");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule